// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a console's CPU and video buses and the memories of a game cartridge. It turns a 16-bit CPU address into a program-ROM address and a 14-bit video-bus address into a pattern-memory address. It also holds the registers that choose the banks.

The CPU sees three program windows. A 16 KB window at 0x8000 and an 8 KB window at 0xC000 can each be switched. A third 8 KB window at 0xE000 always shows the end of program ROM. The video side splits its 8 KB pattern space into eight 1 KB slots, and each slot has its own bank number. The CPU loads the bank numbers and the nametable mirroring code through writes to the 0x8000-0xFFFF space. Writes aimed at the sound registers are only decoded and passed on as one-cycle strobes.

Two board wirings exist. They differ in which of CPU address bits 0 and 1 drives each register-select line. An input pin picks the wiring. A build parameter chooses between banked pattern ROM and a plain 8 KB pattern RAM.

Top module: `cart_bank_mapper`

## Requirements
- R1: For CPU addresses 0x8000-0xBFFF, prg_addr = (B16 * 0x4000 + cpu_addr[13:0]) mod PRG_BYTES. A CPU write anywhere in 0x8000-0x8FFF loads B16 from cpu_data, and the new value is used from the next cycle. For CPU addresses below 0x8000, prg_addr is 0.
- R2: For CPU addresses 0xC000-0xDFFF, prg_addr = (B8 * 0x2000 + cpu_addr[12:0]) mod PRG_BYTES. A write anywhere in 0xC000-0xCFFF loads B8.
- R3: For CPU addresses 0xE000-0xFFFF, prg_addr = PRG_BYTES - 0x2000 + cpu_addr[12:0], whatever is in the bank registers.
- R4: The 2-bit register select is {cpu_addr[1], cpu_addr[0]} (bit1, bit0) when board_swap is 0. It is {cpu_addr[0], cpu_addr[1]} when board_swap is 1.
- R5: A write in 0xD000-0xDFFF loads pattern slot number select (0-3). A write in 0xE000-0xEFFF loads slot 4 + select.
- R6: In the ROM variant, slot = ppu_addr[12:10] and chr_addr = (slot bank * 0x400 + ppu_addr[9:0]) mod CHR_BYTES, with chr_wr_en held at 0. In the RAM variant, chr_addr = ppu_addr[12:0] and chr_wr_en follows ppu_wr.
- R7: A write in 0xB000-0xBFFF with select 3 sets mirror_mode to cpu_data[3:2] from the next cycle. The codes are 0 vertical, 1 horizontal, 2 single screen page 0 and 3 single screen page 1.
- R8: During a write cycle, snd_wr bit (3*ch + select) is high. The channel ch is 0 for 0x9000-0x9FFF, 1 for 0xA000-0xAFFF and 2 for 0xB000-0xBFFF. Select 3 raises no strobe, and at most one bit is ever high.
- R9: After reset, B16 = 0, B8 = 1, pattern slot n holds bank n, and mirror_mode equals MIRROR_INIT (default 0).
- R10: The following writes change no bank number and no mirroring code: writes below 0x8000, writes in 0xF000-0xFFFF, and select-3 writes in 0x9000-0xAFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_swap | input | 1 | Selects the board wiring of the register-select lines |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write cycle |
| ppu_addr | input | 14 | Video-bus address |
| ppu_wr | input | 1 | Video-bus write cycle |
| prg_addr | output | PRG_AW | Translated program-ROM address |
| chr_addr | output | CHR_AW | Translated pattern-memory address |
| chr_wr_en | output | 1 | Pattern RAM write enable (RAM variant only) |
| mirror_mode | output | 2 | Nametable mirroring code |
| snd_wr | output | 9 | Sound-register write strobes |

## Verification
The bank and mirroring registers are the only state, and every one of them shows up on an output address. A wrong B16 or B8 value corrupts the upper bits of prg_addr on the first read of that window. A wrong slot bank corrupts chr_addr[CHR_AW-1:10] on the first fetch from that 1 KB slot. A wrong mirroring code appears on mirror_mode in the cycle after the write. Each output is therefore compared against the model in every cycle, and after each write the bench reads the affected window or slot. A wrong register select or wiring swap then shows up one cycle after the write that misrouted it, or at once on snd_wr.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

   typedef logic [7:0] bank_t;
   typedef bank_t [7:0] chr_bank_vec_t;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_PAGE0 = 2'd2,
      MIR_PAGE1 = 2'd3
   } mirror_e;

   typedef enum logic [1:0] {
      WIN_NONE,
      WIN_SW16,
      WIN_SW8,
      WIN_FIXED
   } prg_win_e;

   localparam int SND_CHANNELS = 3;
   localparam int SND_REGS     = 3;
   localparam int SND_STROBES  = SND_CHANNELS * SND_REGS;
   localparam int CHR_SLOTS    = 8;
   localparam int PRG_OFF_W    = 22;
   localparam int CHR_OFF_W    = 18;

   localparam logic [3:0] PG_PRG16  = 4'h8;
   localparam logic [3:0] PG_SND0   = 4'h9;
   localparam logic [3:0] PG_MIRROR = 4'hB;
   localparam logic [3:0] PG_PRG8   = 4'hC;
   localparam logic [3:0] PG_CHR_LO = 4'hD;
   localparam logic [3:0] PG_CHR_HI = 4'hE;

   function automatic logic [1:0] reg_select(input logic [1:0] low_addr, input logic swap);
      return swap ? {low_addr[0], low_addr[1]} : low_addr;
   endfunction

   function automatic prg_win_e prg_window(input logic [2:0] top3);
      unique case (top3)
         3'b100, 3'b101: return WIN_SW16;
         3'b110:         return WIN_SW8;
         3'b111:         return WIN_FIXED;
         default:        return WIN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cart_reg_decode.sv
module cart_reg_decode
   import cart_map_pkg::*;
#(
   parameter logic [1:0] MIRROR_INIT = 2'd0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   board_swap,
   input  logic                   cpu_wr,
   input  logic [15:0]            cpu_addr,
   input  logic [7:0]             cpu_data,
   output bank_t                  prg_bank16,
   output bank_t                  prg_bank8,
   output chr_bank_vec_t          chr_banks,
   output logic [1:0]             mirror_mode,
   output logic [SND_STROBES-1:0] snd_wr
);

   logic [3:0] page;
   logic [1:0] sel;
   logic       hit;
   logic       ld_prg16;
   logic       ld_prg8;
   logic       ld_mirror;
   mirror_e    mirror_q;
   logic       unused_addr_bits;

   assign page = cpu_addr[15:12];
   assign hit  = cpu_wr & cpu_addr[15];
   assign sel  = reg_select(cpu_addr[1:0], board_swap);
   assign unused_addr_bits = ^cpu_addr[11:2];

   assign ld_prg16  = hit && (page == PG_PRG16);
   assign ld_prg8   = hit && (page == PG_PRG8);
   assign ld_mirror = hit && (page == PG_MIRROR) && (sel == 2'd3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prg_bank16 <= bank_t'(0);
         prg_bank8  <= bank_t'(1);
         mirror_q   <= mirror_e'(MIRROR_INIT);
      end else begin
         if (ld_prg16)  prg_bank16 <= cpu_data;
         if (ld_prg8)   prg_bank8  <= cpu_data;
         if (ld_mirror) mirror_q   <= mirror_e'(cpu_data[3:2]);
      end
   end

   assign mirror_mode = mirror_q;

   for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_slot
      localparam logic [3:0] SLOT_PAGE = (g < 4) ? PG_CHR_LO : PG_CHR_HI;
      localparam logic [1:0] SLOT_SEL  = 2'(g % 4);
      logic load;
      assign load = hit && (page == SLOT_PAGE) && (sel == SLOT_SEL);
      always_ff @(posedge clk) begin
         if (!rst_n)    chr_banks[g] <= bank_t'(g);
         else if (load) chr_banks[g] <= cpu_data;
      end
   end

   for (genvar ch = 0; ch < SND_CHANNELS; ch++) begin : g_snd_ch
      localparam logic [3:0] CH_PAGE = 4'(PG_SND0 + ch);
      for (genvar r = 0; r < SND_REGS; r++) begin : g_snd_reg
         assign snd_wr[ch*SND_REGS + r] = hit && (page == CH_PAGE) && (sel == 2'(r));
      end
   end

endmodule

// File: rtl/cart_prg_xlate.sv
module cart_prg_xlate
   import cart_map_pkg::*;
#(
   parameter int PRG_BYTES = 262144,
   parameter int PRG_AW    = $clog2(PRG_BYTES)
) (
   input  logic [15:0]       cpu_addr,
   input  bank_t             bank16,
   input  bank_t             bank8,
   output logic [PRG_AW-1:0] prg_addr
);

   localparam int FIX_ONES = PRG_OFF_W - 13;

   logic [PRG_OFF_W-1:0] off_sw16;
   logic [PRG_OFF_W-1:0] off_sw8;
   logic [PRG_OFF_W-1:0] off_fixed;
   logic [PRG_OFF_W-1:0] off_sel;
   prg_win_e             win;
   logic                 unused_off_bits;

   assign win       = prg_window(cpu_addr[15:13]);
   assign off_sw16  = {bank16, cpu_addr[13:0]};
   assign off_sw8   = {1'b0, bank8, cpu_addr[12:0]};
   assign off_fixed = {{FIX_ONES{1'b1}}, cpu_addr[12:0]};

   always_comb begin
      unique case (win)
         WIN_SW16:  off_sel = off_sw16;
         WIN_SW8:   off_sel = off_sw8;
         WIN_FIXED: off_sel = off_fixed;
         default:   off_sel = '0;
      endcase
   end

   assign prg_addr = off_sel[PRG_AW-1:0];

   if (PRG_AW < PRG_OFF_W) begin : g_trim
      assign unused_off_bits = ^off_sel[PRG_OFF_W-1:PRG_AW];
   end else begin : g_full
      assign unused_off_bits = 1'b0;
   end

endmodule

// File: rtl/cart_chr_xlate.sv
module cart_chr_xlate
   import cart_map_pkg::*;
#(
   parameter int CHR_BYTES  = 131072,
   parameter bit CHR_IS_RAM = 1'b0,
   parameter int CHR_AW     = $clog2(CHR_BYTES)
) (
   input  logic [13:0]       ppu_addr,
   input  logic              ppu_wr,
   input  chr_bank_vec_t     chr_banks,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_wr_en
);

   if (CHR_IS_RAM) begin : g_ram
      logic unused_ram_in;
      assign unused_ram_in = ^{chr_banks, ppu_addr[13]};
      assign chr_addr  = ppu_addr[CHR_AW-1:0];
      assign chr_wr_en = ppu_wr;
   end else begin : g_rom
      logic [2:0]           slot;
      bank_t                slot_bank;
      logic [CHR_OFF_W-1:0] off;
      logic                 unused_rom_in;

      assign slot      = ppu_addr[12:10];
      assign slot_bank = chr_banks[slot];
      assign off       = {slot_bank, ppu_addr[9:0]};
      assign chr_addr  = off[CHR_AW-1:0];
      assign chr_wr_en = 1'b0;

      if (CHR_AW < CHR_OFF_W) begin : g_trim
         assign unused_rom_in = ^{ppu_wr, ppu_addr[13], off[CHR_OFF_W-1:CHR_AW]};
      end else begin : g_full
         assign unused_rom_in = ^{ppu_wr, ppu_addr[13]};
      end
   end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cart_map_pkg::*;
#(
   parameter int         PRG_BYTES   = 262144,
   parameter int         CHR_BYTES   = 131072,
   parameter bit         CHR_IS_RAM  = 1'b0,
   parameter logic [1:0] MIRROR_INIT = 2'd0,
   parameter int         PRG_AW      = $clog2(PRG_BYTES),
   parameter int         CHR_AW      = $clog2(CHR_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              board_swap,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_data,
   input  logic              cpu_wr,
   input  logic [13:0]       ppu_addr,
   input  logic              ppu_wr,
   output logic [PRG_AW-1:0] prg_addr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_wr_en,
   output logic [1:0]        mirror_mode,
   output logic [8:0]        snd_wr
);

   if ((PRG_BYTES & (PRG_BYTES - 1)) != 0 || PRG_BYTES < 32768 || PRG_BYTES > 4194304) begin : g_bad_prg
      $error("PRG_BYTES must be a power of two from 32768 to 4194304");
   end
   if ((CHR_BYTES & (CHR_BYTES - 1)) != 0 || CHR_BYTES < 8192 || CHR_BYTES > 262144) begin : g_bad_chr
      $error("CHR_BYTES must be a power of two from 8192 to 262144");
   end
   if (CHR_IS_RAM && CHR_BYTES != 8192) begin : g_bad_ram
      $error("pattern RAM variant requires CHR_BYTES of 8192");
   end
   if (PRG_AW != $clog2(PRG_BYTES) || CHR_AW != $clog2(CHR_BYTES)) begin : g_bad_aw
      $error("address widths must follow the memory sizes");
   end
   if (SND_STROBES != 9) begin : g_bad_snd
      $error("sound strobe count mismatch");
   end

   bank_t         bank16;
   bank_t         bank8;
   chr_bank_vec_t chr_banks;

   cart_reg_decode #(
      .MIRROR_INIT (MIRROR_INIT)
   ) i_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .board_swap  (board_swap),
      .cpu_wr      (cpu_wr),
      .cpu_addr    (cpu_addr),
      .cpu_data    (cpu_data),
      .prg_bank16  (bank16),
      .prg_bank8   (bank8),
      .chr_banks   (chr_banks),
      .mirror_mode (mirror_mode),
      .snd_wr      (snd_wr)
   );

   cart_prg_xlate #(
      .PRG_BYTES (PRG_BYTES),
      .PRG_AW    (PRG_AW)
   ) i_prg (
      .cpu_addr (cpu_addr),
      .bank16   (bank16),
      .bank8    (bank8),
      .prg_addr (prg_addr)
   );

   cart_chr_xlate #(
      .CHR_BYTES  (CHR_BYTES),
      .CHR_IS_RAM (CHR_IS_RAM),
      .CHR_AW     (CHR_AW)
   ) i_chr (
      .ppu_addr  (ppu_addr),
      .ppu_wr    (ppu_wr),
      .chr_banks (chr_banks),
      .chr_addr  (chr_addr),
      .chr_wr_en (chr_wr_en)
   );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
   parameter int PRG_AW     = 18,
   parameter int CHR_AW     = 17,
   parameter bit CHR_IS_RAM = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic [7:0]        cpu_data,
   input logic              cpu_wr,
   input logic [13:0]       ppu_addr,
   input logic              ppu_wr,
   input logic [PRG_AW-1:0] prg_addr,
   input logic [CHR_AW-1:0] chr_addr,
   input logic              chr_wr_en,
   input logic [1:0]        mirror_mode,
   input logic [8:0]        snd_wr
);

   // R1
   bank16_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:12] == 4'h8) |=>
         (cpu_addr[15:14] != 2'b10 ||
          prg_addr[PRG_AW-1:14] == $past(cpu_data[PRG_AW-15:0])));

   // R1
   low_space_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_addr[15] |-> prg_addr == '0);

   // R3
   fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cpu_addr[15:13]) |-> prg_addr == {{(PRG_AW-13){1'b1}}, cpu_addr[12:0]});

   // R6
   chr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_addr[9:0] == ppu_addr[9:0]);

   // R6
   chr_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_wr_en == (CHR_IS_RAM && ppu_wr));

   // R7
   mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:12] == 4'hB && cpu_addr[1:0] == 2'b11) |=>
         mirror_mode == $past(cpu_data[3:2]));

   // R10
   mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_addr[15:12] == 4'hB && cpu_addr[1:0] == 2'b11) |=> $stable(mirror_mode));

   // R8
   snd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(snd_wr));

   // R8
   snd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_addr[15]) |-> snd_wr == '0);

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
   .PRG_AW     (PRG_AW),
   .CHR_AW     (CHR_AW),
   .CHR_IS_RAM (CHR_IS_RAM)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_addr    (cpu_addr),
   .cpu_data    (cpu_data),
   .cpu_wr      (cpu_wr),
   .ppu_addr    (ppu_addr),
   .ppu_wr      (ppu_wr),
   .prg_addr    (prg_addr),
   .chr_addr    (chr_addr),
   .chr_wr_en   (chr_wr_en),
   .mirror_mode (mirror_mode),
   .snd_wr      (snd_wr)
);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;

   localparam int PRGB = 262144;
   localparam int CHRB = 131072;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        board_swap = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic        ppu_wr = 1'b0;
   logic [17:0] prg_addr;
   logic [16:0] chr_addr;
   logic        chr_wr_en;
   logic [1:0]  mirror_mode;
   logic [8:0]  snd_wr;
   logic [17:0] prg_addr_r;
   logic [12:0] chr_addr_r;
   logic        chr_wr_en_r;
   logic [1:0]  mirror_mode_r;
   logic [8:0]  snd_wr_r;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int m_b16;
   int m_b8;
   int m_chr[8];
   int m_mir;

   always #2.5 clk = ~clk;

   cart_bank_mapper i_cart_bank_mapper (
      .clk(clk), .rst_n(rst_n), .board_swap(board_swap),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
      .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .prg_addr(prg_addr), .chr_addr(chr_addr), .chr_wr_en(chr_wr_en),
      .mirror_mode(mirror_mode), .snd_wr(snd_wr)
   );

   cart_bank_mapper #(.CHR_BYTES(8192), .CHR_IS_RAM(1'b1)) i_cart_bank_mapper_ram (
      .clk(clk), .rst_n(rst_n), .board_swap(board_swap),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
      .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .prg_addr(prg_addr_r), .chr_addr(chr_addr_r), .chr_wr_en(chr_wr_en_r),
      .mirror_mode(mirror_mode_r), .snd_wr(snd_wr_r)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sel_of(input int a, input bit swap);
      return swap ? (((a & 1) << 1) | ((a >> 1) & 1)) : (a & 3);
   endfunction

   function automatic int exp_prg(input int a);
      if (a < 'h8000) return 0;
      if (a < 'hC000) return (m_b16 * 'h4000 + (a & 'h3FFF)) % PRGB;
      if (a < 'hE000) return (m_b8 * 'h2000 + (a & 'h1FFF)) % PRGB;
      return PRGB - 'h2000 + (a & 'h1FFF);
   endfunction

   function automatic int exp_snd(input int a, input bit w, input bit swap);
      int n = (a >> 12) & 'hF;
      int s = sel_of(a, swap);
      if (!w || a < 'h8000) return 0;
      if (n >= 9 && n <= 'hB && s != 3) return 1 << ((n - 9) * 3 + s);
      return 0;
   endfunction

   task automatic model_reset();
      m_b16 = 0;
      m_b8 = 1;
      for (int i = 0; i < 8; i++) m_chr[i] = i;
      m_mir = 0;
   endtask

   task automatic model_write(input int a, input int d, input bit swap);
      int n = (a >> 12) & 'hF;
      int s = sel_of(a, swap);
      if (a < 'h8000) return;
      case (n)
         8:    m_b16 = d;
         'hC:  m_b8 = d;
         'hD:  m_chr[s] = d;
         'hE:  m_chr[4 + s] = d;
         'hB:  if (s == 3) m_mir = (d >> 2) & 3;
         default: ;
      endcase
   endtask

   // One bus cycle: apply inputs, compare every output against the model, then clock.
   task automatic cyc(input string tag, input int a, input int d, input bit w,
                      input int p, input bit pw, input bit swap);
      int pa;
      @(negedge clk);
      cpu_addr = 16'(a); cpu_data = 8'(d); cpu_wr = w;
      ppu_addr = 14'(p); ppu_wr = pw; board_swap = swap;
      #1;
      pa = p & 'h1FFF;
      chk(tag, "prg_addr", int'(prg_addr), exp_prg(a));
      chk(tag, "chr_addr", int'(chr_addr), (m_chr[(pa >> 10) & 7] * 'h400 + (pa & 'h3FF)) % CHRB);
      chk(tag, "chr_wr_en", int'(chr_wr_en), 0);
      chk(tag, "mirror_mode", int'(mirror_mode), m_mir);
      chk(tag, "snd_wr", int'(snd_wr), exp_snd(a, w, swap));
      chk(tag, "ram chr_addr", int'(chr_addr_r), pa);
      chk(tag, "ram chr_wr_en", int'(chr_wr_en_r), int'(pw));
      @(posedge clk);
      if (w) model_write(a, d, swap);
   endtask

   task automatic rd(input string tag, input int a, input int p);
      cyc(tag, a, 0, 1'b0, p, 1'b0, 1'b0);
   endtask

   task automatic wr(input string tag, input int a, input int d, input bit swap);
      cyc(tag, a, d, 1'b1, 0, 1'b0, swap);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: reset bank numbers and mirroring
      rd("R9", 'h8123, 'h0000);
      rd("R9", 'hC456, 'h0400);
      for (int s = 0; s < 8; s++) rd("R9", 'hE000 + s, s * 'h400 + 'h3FF);

      // R1: switchable 16 KB window, including wrap beyond ROM size
      wr("R1", 'h8000, 5, 1'b0);
      rd("R1", 'h8123, 0);
      rd("R1", 'hBFFF, 0);
      wr("R1", 'h8FFF, 'h13, 1'b1);
      rd("R1", 'h8004, 0);
      rd("R1", 'h7FFF, 0);

      // R2: switchable 8 KB window
      wr("R2", 'hC000, 7, 1'b0);
      rd("R2", 'hC000, 0);
      rd("R2", 'hDFFF, 0);
      wr("R2", 'hCABC, 'h40, 1'b0);
      rd("R2", 'hD010, 0);

      // R3: fixed last window ignores bank registers
      rd("R3", 'hE000, 0);
      rd("R3", 'hFFFF, 0);

      // R5 and R4: slot loads under both wirings
      wr("R5", 'hD000, 'h20, 1'b0);
      wr("R4", 'hD001, 'h21, 1'b0);
      wr("R4", 'hD002, 'h22, 1'b0);
      wr("R5", 'hE003, 'h37, 1'b0);
      wr("R4", 'hD001, 'h52, 1'b1);
      wr("R4", 'hE002, 'h65, 1'b1);
      wr("R4", 'hE001, 'h66, 1'b1);
      for (int s = 0; s < 8; s++) rd("R6", 'h9000, s * 'h400 + 'h155);
      rd("R6", 'h6000, 'h3FFF);

      // R7: every mirroring code, and a select-2 write on the mirroring page
      wr("R7", 'hB003, 'h08, 1'b0);
      rd("R7", 'h8000, 0);
      wr("R7", 'hBFF3, 'h04, 1'b1);
      wr("R7", 'hB003, 'hFC, 1'b0);
      wr("R7", 'hB002, 'h00, 1'b0);
      wr("R7", 'hB001, 'h00, 1'b1);
      wr("R7", 'hB003, 'h00, 1'b0);
      rd("R7", 'h8000, 0);

      // R8: sound strobes for each channel and select, both wirings
      for (int pg = 9; pg <= 'hB; pg++) begin
         for (int lo = 0; lo < 3; lo++) begin
            wr("R8", (pg << 12) | lo, 'hAA, 1'b0);
            wr("R8", (pg << 12) | 'h10 | lo, 'h55, 1'b1);
         end
      end

      // R10: ignored writes leave banks and mirroring alone
      wr("R10", 'h3003, 'h0C, 1'b0);
      wr("R10", 'h0000, 'hFF, 1'b0);
      wr("R10", 'hF000, 'hFF, 1'b0);
      wr("R10", 'hF001, 'h07, 1'b0);
      wr("R10", 'hF002, 'h07, 1'b1);
      wr("R10", 'h9003, 'h0C, 1'b0);
      wr("R10", 'hA003, 'h0C, 1'b1);
      rd("R10", 'h8222, 'h0000);
      rd("R10", 'hC333, 'h1FFF);
      for (int s = 0; s < 8; s++) rd("R10", 'hA000, s * 'h400);

      // R6: video-bus writes reach only the RAM variant
      cyc("R6", 'h0000, 0, 1'b0, 'h1ABC, 1'b1, 1'b0);
      cyc("R6", 'h0000, 0, 1'b0, 'h2123, 1'b1, 1'b0);
      cyc("R6", 'h0000, 0, 1'b0, 'h0123, 1'b0, 1'b0);

      // R9: reset again restores power-up state
      @(negedge clk);
      rst_n = 1'b0;
      cpu_wr = 1'b0;
      repeat (2) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      rd("R9", 'h8010, 'h0C00);
      rd("R9", 'hC010, 'h1C00);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule